// File: doc/BRIEF.md
# Masked I/O Window Decoder

This block keeps two programmable windows into the 16-bit I/O space and tells a bus bridge whether an incoming I/O cycle belongs to one of them. Each window is set up through one 32-bit configuration word. The word holds three things: an enable bit, a base address at DWord resolution, and a six-bit don't-care mask over address bits 7:2. With the mask, a single base can cover an aligned block of any power-of-two size from 4 to 256 bytes.

Software writes a window word through a simple register port and reads it back on the same port. The decode path has no registers. When the cycle-valid strobe is high, the per-window hit outputs and their OR follow the presented address and the current window contents within the same cycle. The downstream logic uses the combined hit to claim the cycle.

Top module: `io_window_decoder`

## Requirements
- R1: After reset both window words read back as 0x00000000, and no address produces a hit.
- R2: Only bits 23:18, 15:2 and 0 of a window word are stored. Bits 31:24, 17:16 and 1 read back as 0 whatever was written to them.
- R3: Bit 0 of a window word is its enable. While it is 0, that window never hits.
- R4: A window hits only when I/O address bits 15:2 equal word bits 15:2, except in positions that the mask releases.
- R5: Word bit 18+k (k = 0..5) releases address bit 2+k. A released address bit matches either value, and the base bit in that position is ignored.
- R6: Address bits 15:8 are never masked and must always equal base bits 15:8.
- R7: Address bits 1:0 take no part in the comparison.
- R8: An address with any of bits 31:16 set never hits.
- R9: While io_valid is 0, win_hit and any_hit are 0.
- R10: cfg_sel = 0 selects window 0 and cfg_sel = 1 selects window 1. The two windows decode independently: win_hit[i] belongs to window i, and any_hit is the OR of win_hit.
- R11: A write is stored on the clock edge where cfg_we is high. An address decoded in that same cycle still uses the old contents, and the new contents take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Write strobe for the selected window word |
| cfg_sel | input | 1 | Window select for write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Stored word of the selected window, with reserved bits at 0 |
| io_addr | input | 32 | I/O cycle address |
| io_valid | input | 1 | Qualifies io_addr |
| win_hit | output | 2 | Per-window hit |
| any_hit | output | 1 | OR of all window hits |

## Verification
A configuration write and an address decode can happen in the same cycle. The decode must then use the word as it was before that edge. The bench provokes this by rewriting an enabled window to disabled while presenting an address inside it. In that cycle it expects a hit, and in the following cycle it expects none. The checker asserts the same rule for every write that disables a window.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned IO_W      = 16;
  localparam int unsigned BASE_LO   = 2;
  localparam int unsigned BASE_HI   = 15;
  localparam int unsigned BASE_W    = BASE_HI - BASE_LO + 1;
  localparam int unsigned MASK_LO   = 18;
  localparam int unsigned MASK_W    = 6;
  localparam int unsigned EN_BIT    = 0;
  localparam logic [WORD_W-1:0] KEEP_MASK = 32'h00FC_FFFD;

  typedef struct packed {
    logic              en;
    logic [BASE_W-1:0] base;
    logic [MASK_W-1:0] dc;
  } win_cfg_t;

  function automatic win_cfg_t unpack_word(input logic [WORD_W-1:0] w);
    win_cfg_t c;
    c.en   = w[EN_BIT];
    c.base = w[BASE_HI:BASE_LO];
    c.dc   = w[MASK_LO+MASK_W-1:MASK_LO];
    return c;
  endfunction
endpackage

// File: rtl/iowin_reg.sv
module iowin_reg
  import iowin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] q
);
  logic [WORD_W-1:0] q_r;
  logic [WORD_W-1:0] q_d;

  always_comb begin
    q_d = q_r;
    if (wr_en) q_d = wdata & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/iowin_match.sv
module iowin_match
  import iowin_pkg::*;
(
  input  logic [WORD_W-1:0] cfg_word,
  input  logic [WORD_W-1:0] addr,
  input  logic              valid,
  output logic              hit
);
  win_cfg_t          c;
  logic [BASE_W-1:0] care;
  logic [BASE_W-1:0] diff;
  logic              upper_zero;

  always_comb begin
    c          = unpack_word(cfg_word);
    care       = ~{{(BASE_W-MASK_W){1'b0}}, c.dc};
    diff       = (addr[BASE_HI:BASE_LO] ^ c.base) & care;
    upper_zero = (addr[WORD_W-1:IO_W] == '0);
    hit        = valid && c.en && upper_zero && (diff == '0);
  end
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
  import iowin_pkg::*;
#(
  parameter int unsigned NUM_WIN = 2,
  localparam int unsigned SEL_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [WORD_W-1:0]  cfg_wdata,
  output logic [WORD_W-1:0]  cfg_rdata,
  input  logic [WORD_W-1:0]  io_addr,
  input  logic               io_valid,
  output logic [NUM_WIN-1:0] win_hit,
  output logic               any_hit
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [WORD_W-1:0] words [NUM_WIN];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic wr_i;
    assign wr_i = cfg_we && (cfg_sel == SEL_W'(i));

    iowin_reg u_reg (
      .clk   (clk),
      .rst_n (rst_int_n),
      .wr_en (wr_i),
      .wdata (cfg_wdata),
      .q     (words[i])
    );

    iowin_match u_match (
      .cfg_word (words[i]),
      .addr     (io_addr),
      .valid    (io_valid),
      .hit      (win_hit[i])
    );
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (cfg_sel == SEL_W'(i)) cfg_rdata = words[i];
    end
  end

  assign any_hit = |win_hit;
endmodule

// File: rtl/iowin_checker.sv
module iowin_checker
  import iowin_pkg::*;
#(
  parameter int unsigned NUM_WIN = 2,
  localparam int unsigned SEL_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [SEL_W-1:0]   cfg_sel,
  input logic [WORD_W-1:0]  cfg_wdata,
  input logic [WORD_W-1:0]  cfg_rdata,
  input logic [WORD_W-1:0]  io_addr,
  input logic               io_valid,
  input logic [NUM_WIN-1:0] win_hit,
  input logic               any_hit
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= 2'd0;
    else if (age != 3)  age <= age + 2'd1;
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~KEEP_MASK) == '0);

  assert_idle_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !io_valid |-> (win_hit == '0) && !any_hit);

  assert_upper_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr[WORD_W-1:IO_W] != '0) |-> (win_hit == '0));

  assert_any_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit == (win_hit != '0));

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_chk
    assert_disable_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == SEL_W'(k) && !cfg_wdata[EN_BIT]) |=> !win_hit[k]);

    assert_write_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && cfg_we && cfg_sel == SEL_W'(k)) |=>
        ((cfg_sel != SEL_W'(k)) || (cfg_rdata == ($past(cfg_wdata) & KEEP_MASK))));
  end
endmodule

bind io_window_decoder iowin_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .io_addr   (io_addr),
  .io_valid  (io_valid),
  .win_hit   (win_hit),
  .any_hit   (any_hit)
);

// File: tb/io_window_decoder_tb_top.sv
module io_window_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [0:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [31:0] io_addr;
  logic        io_valid;
  logic [1:0]  win_hit;
  logic        any_hit;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  io_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
    .io_valid(io_valid), .win_hit(win_hit), .any_hit(any_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic sel, input logic [31:0] exp);
    cfg_sel = sel; #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic look(input string req, input logic [31:0] a, input logic v,
                      input logic [1:0] exp);
    io_addr = a; io_valid = v; #1;
    check(req, {30'd0, win_hit}, {30'd0, exp});
    check(req, {31'd0, any_hit}, {31'd0, |exp});
  endtask

  task automatic t_reset;
    rd("R1", 1'b0, 32'h0);
    rd("R1", 1'b1, 32'h0);
    look("R1", 32'h0, 1'b1, 2'b00);
    look("R1", 32'h0000_0A00, 1'b1, 2'b00);
  endtask

  task automatic t_reserved;
    wr(1'b0, 32'hFFFF_FFFF);
    rd("R2", 1'b0, 32'h00FC_FFFD);
    wr(1'b0, 32'h0000_0000);
    rd("R2", 1'b0, 32'h0);
  endtask

  task automatic t_enable;
    wr(1'b0, 32'h0000_0400);
    look("R3", 32'h0000_0400, 1'b1, 2'b00);
    wr(1'b0, 32'h0000_0401);
    look("R3", 32'h0000_0400, 1'b1, 2'b01);
  endtask

  task automatic t_base;
    wr(1'b0, 32'h0000_0A01);
    look("R4", 32'h0000_0A00, 1'b1, 2'b01);
    look("R4", 32'h0000_0A04, 1'b1, 2'b00);
    look("R4", 32'h0000_0A08, 1'b1, 2'b00);
    look("R4", 32'h0000_0E00, 1'b1, 2'b00);
  endtask

  task automatic t_mask;
    wr(1'b0, 32'h00FC_0A01);
    look("R5", 32'h0000_0A00, 1'b1, 2'b01);
    look("R5", 32'h0000_0AFC, 1'b1, 2'b01);
    look("R5", 32'h0000_0A54, 1'b1, 2'b01);
    wr(1'b0, 32'h0010_0A01);
    look("R5", 32'h0000_0A10, 1'b1, 2'b01);
    look("R5", 32'h0000_0A14, 1'b1, 2'b00);
    wr(1'b0, 32'h00FC_0A41);
    look("R5", 32'h0000_0A80, 1'b1, 2'b01);
  endtask

  task automatic t_high;
    wr(1'b0, 32'h00FC_0A01);
    look("R6", 32'h0000_0B00, 1'b1, 2'b00);
    look("R6", 32'h0000_1A00, 1'b1, 2'b00);
    look("R6", 32'h0000_8A00, 1'b1, 2'b00);
  endtask

  task automatic t_low;
    wr(1'b0, 32'h0000_0A05);
    rd("R7", 1'b0, 32'h0000_0A05);
    look("R7", 32'h0000_0A05, 1'b1, 2'b01);
    look("R7", 32'h0000_0A07, 1'b1, 2'b01);
    look("R7", 32'h0000_0A03, 1'b1, 2'b00);
  endtask

  task automatic t_upper;
    look("R8", 32'h0001_0A04, 1'b1, 2'b00);
    look("R8", 32'h8000_0A04, 1'b1, 2'b00);
  endtask

  task automatic t_valid;
    look("R9", 32'h0000_0A04, 1'b0, 2'b00);
    look("R9", 32'h0000_0A04, 1'b1, 2'b01);
  endtask

  task automatic t_two;
    wr(1'b0, 32'h0000_0301);
    wr(1'b1, 32'h00FC_0401);
    rd("R10", 1'b0, 32'h0000_0301);
    rd("R10", 1'b1, 32'h00FC_0401);
    look("R10", 32'h0000_0300, 1'b1, 2'b01);
    look("R10", 32'h0000_0420, 1'b1, 2'b10);
    look("R10", 32'h0000_0500, 1'b1, 2'b00);
    wr(1'b1, 32'h0000_0301);
    look("R10", 32'h0000_0300, 1'b1, 2'b11);
  endtask

  task automatic t_same_cycle;
    wr(1'b1, 32'h0);
    wr(1'b0, 32'h0000_0301);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h0000_0300;
    look("R11", 32'h0000_0300, 1'b1, 2'b01);
    @(negedge clk);
    cfg_we = 1'b0;
    look("R11", 32'h0000_0300, 1'b1, 2'b00);
    rd("R11", 1'b0, 32'h0000_0300);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    io_addr = '0; io_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_reserved();
    t_enable();
    t_base();
    t_mask();
    t_high();
    t_low();
    t_upper();
    t_valid();
    t_two();
    t_same_cycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule